// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five localities (0 to 4) owns a shared command interface. Each locality has an 8-bit access register. A bus master picks a locality by writing a locality-select register, then reads or writes that locality's access register. Writes to an access register can request ownership, seize it, give it up, or clear a seized flag. Reads show the locality's view: whether it owns the interface, whether it is waiting, whether someone else is waiting, and whether it lost ownership to a seize.

Ownership follows a fixed priority. Any locality may take a free interface by requesting it. A locality can take a busy interface only by seizing it, and only from a lower-numbered owner. When the owner gives up the interface, the highest-numbered waiting locality takes over in the same cycle.

Locality 4 is kept for hardware. It is driven only by two strobe inputs, and bus writes cannot make it request or seize. The current owner number and an owner-valid flag are driven, registered, to downstream logic.

Top module: `locarb_top`

## Requirements
- R1: After reset no locality owns the interface (`active_vld`=0), the locality select is 0, and every access register reads 8'h81.
- R2: An access register read (address 0) always has bit 7 (register valid) and bit 0 (establishment) set. Bit 5 means "owner", bit 4 "been seized", bit 2 "pending request", bit 1 "request use". Bits 6 and 3 read 0.
- R3: When no locality owns the interface, an access write with bit 1 set makes the selected locality the owner at once. A locality that is granted ownership by any route reads its bit 1 as 0.
- R4: When another locality owns the interface, an access write with bit 1 set does not grant ownership. It sets bit 1 in the writer's own register. A write with bit 1 from the current owner has no effect.
- R5: An access write with bit 3 (seize) from a locality numbered at or below the owner is ignored, and the owner is unchanged.
- R6: A seize write from a locality numbered above the owner, or when there is no owner, makes that locality the owner at once. The previous owner, if there was one, reads bit 4 as 1.
- R7: An access write with bit 4 set clears that locality's been-seized flag.
- R8: An access write with bit 5 set from the owner releases ownership. The highest-numbered locality with bit 1 set becomes owner in the same cycle, or no locality owns if none is waiting. Bit 5 written by a non-owner has no effect. In one write, bit 5 takes precedence over bit 3, and bit 3 over bit 1.
- R9: Bit 2 of locality L reads 1 exactly when some locality other than L has an outstanding request.
- R10: A locality-select write (address 1) with a value above 4 is ignored and the previous selection is kept. Address 1 reads the selection in bits 2:0, with bits 7:3 zero.
- R11: Bus access writes made while locality 4 is selected cannot request or seize. A `hw_seize` strobe makes locality 4 owner, with seize semantics. A `hw_release` strobe releases it as in R8. In a cycle with a strobe, a bus write to address 0 is dropped (`hw_seize` wins over `hw_release`).
- R12: Reads of addresses 2 and 3 return 8'hFF. Writes to them change nothing.
- R13: `active_loc` and `active_vld` follow the owner one clock after the write or strobe that changed it. Read data appears one clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 access register, 1 locality select, others unsupported |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| hw_seize | input | 1 | Locality 4 seize strobe |
| hw_release | input | 1 | Locality 4 release strobe |
| active_loc | output | 3 | Current owner number |
| active_vld | output | 1 | An owner exists |

## Verification
A sweep takes every owner from 0 to 3 and has every other bus locality try a request and then a seize. This separates the lower-versus-higher priority paths and the pending flag seen by each viewer. A full-queue release chain checks that hand-over always goes to the highest waiter. Separate runs cover rejected select values, the locality 4 strobes (including a strobe in the same cycle as a bus write), and unsupported addresses. A pseudo-random stream of mixed-bit writes and strobes, with all five registers compared against a bench model after each step, tests the precedence between bits in one write.

// File: rtl/locarb_pkg.sv
`timescale 1ns/1ps
package locarb_pkg;
  localparam int BIT_EST    = 0;
  localparam int BIT_REQ    = 1;
  localparam int BIT_PEND   = 2;
  localparam int BIT_SEIZE  = 3;
  localparam int BIT_SEIZED = 4;
  localparam int BIT_ACT    = 5;
  localparam int BIT_VALID  = 7;

  localparam int ADDR_ACC = 0;
  localparam int ADDR_SEL = 1;

  typedef struct packed {
    logic release_own;
    logic seize;
    logic request;
    logic clr_seized;
  } acc_cmd_t;
endpackage

// File: rtl/locarb_sel_reg.sv
`timescale 1ns/1ps
module locarb_sel_reg #(
  parameter int NUM_LOC = 5,
  parameter int LW      = 3,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [LW-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_en && (int'(wdata) < NUM_LOC)) begin
      sel_q <= wdata[LW-1:0];
    end
  end
endmodule

// File: rtl/locarb_own_core.sv
`timescale 1ns/1ps
module locarb_own_core
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_wr,
  input  logic [LW-1:0]      wr_loc,
  input  acc_cmd_t           cmd,
  input  logic               hw_seize,
  input  logic               hw_release,
  output logic [LW-1:0]      owner_q,
  output logic               own_vld_q,
  output logic [NUM_LOC-1:0] req_q,
  output logic [NUM_LOC-1:0] seized_q
);
  localparam logic [LW-1:0] HW_LOC = LW'(NUM_LOC - 1);

  logic [LW-1:0]      owner_n, pick;
  logic               vld_n, do_rel;
  logic [NUM_LOC-1:0] req_n, seized_n;

  // highest-numbered waiting locality
  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_LOC; k++) begin
      if (req_q[k]) pick = LW'(k);
    end
  end

  always_comb begin
    owner_n  = owner_q;
    vld_n    = own_vld_q;
    req_n    = req_q;
    seized_n = seized_q;
    do_rel   = 1'b0;
    if (hw_seize) begin
      if (!(own_vld_q && owner_q == HW_LOC)) begin
        if (own_vld_q) seized_n[owner_q] = 1'b1;
        owner_n         = HW_LOC;
        vld_n           = 1'b1;
        req_n[HW_LOC]   = 1'b0;
      end
    end else if (hw_release) begin
      if (own_vld_q && owner_q == HW_LOC) do_rel = 1'b1;
    end else if (acc_wr) begin
      if (cmd.clr_seized) seized_n[wr_loc] = 1'b0;
      if (cmd.release_own) begin
        if (own_vld_q && owner_q == wr_loc) do_rel = 1'b1;
      end else if (cmd.seize && wr_loc != HW_LOC) begin
        if (!own_vld_q || wr_loc > owner_q) begin
          if (own_vld_q) seized_n[owner_q] = 1'b1;
          owner_n       = wr_loc;
          vld_n         = 1'b1;
          req_n[wr_loc] = 1'b0;
        end
      end else if (cmd.request && wr_loc != HW_LOC) begin
        if (!own_vld_q) begin
          owner_n       = wr_loc;
          vld_n         = 1'b1;
          req_n[wr_loc] = 1'b0;
        end else if (owner_q != wr_loc) begin
          req_n[wr_loc] = 1'b1;
        end
      end
    end
    if (do_rel) begin
      if (|req_q) begin
        owner_n     = pick;
        req_n[pick] = 1'b0;
      end else begin
        vld_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= '0;
      own_vld_q <= 1'b0;
      req_q     <= '0;
      seized_q  <= '0;
    end else begin
      owner_q   <= owner_n;
      own_vld_q <= vld_n;
      req_q     <= req_n;
      seized_q  <= seized_n;
    end
  end
endmodule

// File: rtl/locarb_rd_port.sv
`timescale 1ns/1ps
module locarb_rd_port
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LW      = 3,
  parameter int AW      = 2,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [LW-1:0]      sel,
  input  logic [LW-1:0]      owner,
  input  logic               own_vld,
  input  logic [NUM_LOC-1:0] req_q,
  input  logic [NUM_LOC-1:0] seized_q,
  output logic [DW-1:0]      rdata
);
  logic [NUM_LOC-1:0] others;
  logic [DW-1:0]      acc_val;

  always_comb begin
    others       = req_q;
    others[sel]  = 1'b0;
    acc_val      = '0;
    acc_val[BIT_VALID]  = 1'b1;
    acc_val[BIT_EST]    = 1'b1;
    acc_val[BIT_ACT]    = own_vld && (owner == sel);
    acc_val[BIT_SEIZED] = seized_q[sel];
    acc_val[BIT_PEND]   = |others;
    acc_val[BIT_REQ]    = req_q[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == AW'(ADDR_ACC))      rdata <= acc_val;
      else if (addr == AW'(ADDR_SEL)) rdata <= DW'(sel);
      else                            rdata <= '1;
    end
  end
endmodule

// File: rtl/locarb_top.sv
`timescale 1ns/1ps
module locarb_top
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter int LW      = $clog2(NUM_LOC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          hw_seize,
  input  logic          hw_release,
  output logic [LW-1:0] active_loc,
  output logic          active_vld
);
  logic [LW-1:0]      sel_q;
  logic [NUM_LOC-1:0] req_q, seized_q;
  logic               acc_wr, sel_wr;
  acc_cmd_t           cmd;

  assign acc_wr = bus_wr && (bus_addr == AW'(ADDR_ACC));
  assign sel_wr = bus_wr && (bus_addr == AW'(ADDR_SEL));

  assign cmd.release_own = bus_wdata[BIT_ACT];
  assign cmd.seize       = bus_wdata[BIT_SEIZE];
  assign cmd.request     = bus_wdata[BIT_REQ];
  assign cmd.clr_seized  = bus_wdata[BIT_SEIZED];

  locarb_sel_reg #(.NUM_LOC(NUM_LOC), .LW(LW), .DW(DW)) u_sel (
    .clk(clk), .rst(rst), .wr_en(sel_wr), .wdata(bus_wdata), .sel_q(sel_q)
  );

  locarb_own_core #(.NUM_LOC(NUM_LOC), .LW(LW)) u_core (
    .clk(clk), .rst(rst), .acc_wr(acc_wr), .wr_loc(sel_q), .cmd(cmd),
    .hw_seize(hw_seize), .hw_release(hw_release),
    .owner_q(active_loc), .own_vld_q(active_vld),
    .req_q(req_q), .seized_q(seized_q)
  );

  locarb_rd_port #(.NUM_LOC(NUM_LOC), .LW(LW), .AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr), .sel(sel_q),
    .owner(active_loc), .own_vld(active_vld), .req_q(req_q),
    .seized_q(seized_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/locarb_chk.sv
`timescale 1ns/1ps
module locarb_chk #(
  parameter int NUM_LOC = 5,
  parameter int AW      = 2,
  parameter int DW      = 8,
  parameter int LW      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic               hw_seize,
  input logic               hw_release,
  input logic [LW-1:0]      active_loc,
  input logic               active_vld,
  input logic [LW-1:0]      sel_q,
  input logic [NUM_LOC-1:0] req_q
);
  p_owner_not_waiting_r3: assert property (@(posedge clk) disable iff (rst)
    active_vld |-> !req_q[active_loc]);

  p_sel_in_range_r10: assert property (@(posedge clk) disable iff (rst)
    int'(sel_q) < NUM_LOC);

  p_low_seize_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && bus_wdata[3] && !bus_wdata[5] &&
     !hw_seize && !hw_release && active_vld && sel_q <= active_loc)
    |=> (active_vld && active_loc == $past(active_loc)));

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == '0) |=> (bus_rdata[7] && bus_rdata[0]));

  p_hw_seize_wins_r11: assert property (@(posedge clk) disable iff (rst)
    hw_seize |=> (active_vld && int'(active_loc) == NUM_LOC - 1));

  p_unsup_read_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) > 1) |=> (bus_rdata == '1));
endmodule

bind locarb_top locarb_chk #(.NUM_LOC(NUM_LOC), .AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_seize(hw_seize),
  .hw_release(hw_release), .active_loc(active_loc), .active_vld(active_vld),
  .sel_q(sel_q), .req_q(req_q)
);

// File: tb/locarb_top_tb_top.sv
`timescale 1ns/1ps
module locarb_top_tb_top;
  localparam int NL = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       hw_seize = 1'b0, hw_release = 1'b0;
  logic [2:0] active_loc;
  logic       active_vld;

  always #2 clk = ~clk;

  locarb_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_seize(hw_seize),
    .hw_release(hw_release), .active_loc(active_loc), .active_vld(active_vld)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  int     m_own = 0;
  bit     m_vld = 0;
  bit     m_req[NL];
  bit     m_sz[NL];
  int     m_sel = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_release();
    int p = -1;
    for (int k = 0; k < NL; k++) if (m_req[k]) p = k;
    if (p >= 0) begin m_own = p; m_req[p] = 0; end
    else m_vld = 0;
  endtask

  task automatic m_acc_write(input logic [7:0] d);
    int l = m_sel;
    if (d[4]) m_sz[l] = 0;
    if (d[5]) begin
      if (m_vld && m_own == l) m_release();
    end else if (d[3] && l != NL-1) begin
      if (!m_vld || l > m_own) begin
        if (m_vld) m_sz[m_own] = 1;
        m_own = l; m_vld = 1; m_req[l] = 0;
      end
    end else if (d[1] && l != NL-1) begin
      if (!m_vld) begin m_own = l; m_vld = 1; m_req[l] = 0; end
      else if (m_own != l) m_req[l] = 1;
    end
  endtask

  task automatic m_hw(input bit s, input bit r);
    if (s) begin
      if (!(m_vld && m_own == NL-1)) begin
        if (m_vld) m_sz[m_own] = 1;
        m_own = NL-1; m_vld = 1; m_req[NL-1] = 0;
      end
    end else if (r) begin
      if (m_vld && m_own == NL-1) m_release();
    end
  endtask

  function automatic logic [7:0] exp_acc(input int l);
    logic [7:0] v = 8'h81;
    bit p = 0;
    for (int k = 0; k < NL; k++) if (k != l && m_req[k]) p = 1;
    v[5] = m_vld && m_own == l;
    v[4] = m_sz[l];
    v[2] = p;
    v[1] = m_req[l];
    return v;
  endfunction

  task automatic drive_wr(input logic [1:0] a, input logic [7:0] d, input bit s, input bit r);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; hw_seize = s; hw_release = r;
    @(negedge clk);
    bus_wr = 1'b0; hw_seize = 1'b0; hw_release = 1'b0;
    if (s || r) m_hw(s, r);
    else if (a == 2'd0) m_acc_write(d);
    else if (a == 2'd1 && d < NL) m_sel = d;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drive_wr(a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic acc_wr(input int l, input logic [7:0] d);
    wr(2'd1, 8'(l));
    wr(2'd0, d);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int l = 0; l < NL; l++) begin
      wr(2'd1, 8'(l));
      rd(2'd0, v);
      chk(v == exp_acc(l), $sformatf("%s loc%0d", tag, l), v, exp_acc(l));
    end
    chk(active_vld == m_vld, {tag, " R13 vld"}, active_vld, m_vld);
    if (m_vld) chk(active_loc == m_own, {tag, " R13 loc"}, active_loc, m_own);
  endtask

  task automatic clear_all();
    for (int l = 0; l < NL; l++) m_req[l] = m_req[l];
    while (m_vld) begin
      if (m_own == NL-1) drive_wr(2'd0, 8'h00, 1'b0, 1'b1);
      else acc_wr(m_own, 8'h20);
    end
    for (int l = 0; l < NL; l++) acc_wr(l, 8'h10);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] lfsr = 16'hACE1;
    for (int k = 0; k < NL; k++) begin m_req[k] = 0; m_sz[k] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(active_vld == 1'b0, "R1 reset vld", active_vld, 0);
    rd(2'd1, v);
    chk(v == 8'h00, "R1 reset select", v, 0);
    check_all("R1 R2 reset");

    // R3 R4 R5 R6 R9 sweep over owner/contender pairs
    for (int a = 0; a < NL-1; a++) begin
      for (int b = 0; b < NL-1; b++) begin
        if (b == a) continue;
        acc_wr(a, 8'h02);
        check_all("R3 grant");
        acc_wr(b, 8'h02);
        check_all("R4 R9 request");
        acc_wr(b, 8'h08);
        check_all(b > a ? "R6 seize high" : "R5 seize low");
        acc_wr(b, 8'h10);
        acc_wr(a, 8'h10);
        check_all("R7 clear");
        clear_all();
        check_all("R8 drained");
      end
    end

    // R8 hand-over chain
    acc_wr(0, 8'h02);
    for (int l = 1; l < NL-1; l++) acc_wr(l, 8'h02);
    acc_wr(2, 8'h20);
    check_all("R8 non-owner release");
    for (int l = 0; l < NL-1; l++) begin
      acc_wr(m_own, 8'h20);
      check_all("R8 R9 chain");
    end

    // R10 select rejection
    wr(2'd1, 8'd3);
    foreach (v[i]) if (i == 0) begin end
    wr(2'd1, 8'd5);
    rd(2'd1, v); chk(v == 8'd3, "R10 sel 5", v, 3);
    wr(2'd1, 8'd255);
    rd(2'd1, v); chk(v == 8'd3, "R10 sel 255", v, 3);
    wr(2'd1, 8'd4);
    rd(2'd1, v); chk(v == 8'd4, "R10 sel 4", v, 4);

    // R11 locality 4
    acc_wr(4, 8'h02);
    check_all("R11 bus req loc4");
    acc_wr(4, 8'h08);
    check_all("R11 bus seize loc4");
    acc_wr(2, 8'h02);
    acc_wr(1, 8'h02);
    drive_wr(2'd0, 8'h00, 1'b1, 1'b0);
    check_all("R11 hw seize");
    wr(2'd1, 8'd3);
    drive_wr(2'd0, 8'h08, 1'b0, 1'b1);
    check_all("R11 hw release with dropped bus write");
    drive_wr(2'd0, 8'h20, 1'b1, 1'b1);
    check_all("R11 seize wins");
    clear_all();

    // R12 unsupported addresses
    rd(2'd2, v); chk(v == 8'hFF, "R12 addr2", v, 8'hFF);
    rd(2'd3, v); chk(v == 8'hFF, "R12 addr3", v, 8'hFF);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h08);
    check_all("R12 write ignored");

    // mixed stream
    for (int i = 0; i < 300; i++) begin
      int op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[2:0];
      if (op == 7) drive_wr(2'd0, lfsr[15:8], lfsr[3], lfsr[4]);
      else begin
        wr(2'd1, 8'(int'(lfsr[6:4]) % NL));
        case (lfsr[9:8])
          2'd0: wr(2'd0, 8'h02);
          2'd1: wr(2'd0, 8'h08);
          2'd2: wr(2'd0, 8'h20);
          default: wr(2'd0, lfsr[15:8]);
        endcase
      end
      check_all("R2 R8 R9 stream");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule